// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Aggregator

This block gathers interrupt events for a communications controller and presents them to a host processor through a small register bus. The bus has an address, write data, a write strobe, a read strobe and combinational read data. Event sources are single-cycle pulses. Five of them go directly into the primary status register. The rest go into three extended status registers: one for the signalling channel and one for each of the two bearer channels. Each extended register is summarised by one bit of the primary status register.

A mask register hides primary bits from both the host and the interrupt line. A hidden event is not dropped. It stays pending and shows up as soon as its mask bit returns to zero. A read of the primary register clears the direct bits it returned. It leaves the three summary bits alone. Those clear only when their extended registers clear, and each extended register clears when it is read. A single active-high output, `irqOut`, is raised while any unmasked primary bit is pending.

Top module: `irq_tree`

## Requirements
- R1: After reset, the mask register reads FFh, and the primary status and every extended register read 00h. `irqOut` is low.
- R2: Primary bit layout is bit7 rx-message-ready (`evPrim[4]`), bit6 rx-message-end (`evPrim[3]`), bit5 tx-ready (`evPrim[2]`), bit4 external-1 (`evPrim[1]`), bit3 external-0 (`evPrim[0]`), bit2 signalling summary, bit1 bearer-1 summary, bit0 bearer-2 summary. An event pulse latches its bit. The mask register uses the same layout.
- R3: A read of the primary register at `PRIM_ADDR` clears the direct bits it returned and leaves the summary bits unchanged.
- R4: A primary bit whose mask bit is 1 reads as 0. It is not cleared by a primary read, and it reads as 1 once its mask bit is written to 0.
- R5: The signalling extended register at 07h holds `evSig[6:0]` in bits 7..1; bit 0 always reads 0. It clears when read. Its summary bit is 1 exactly while any of its bits is set.
- R6: The bearer extended registers at `B1_ADDR` and `B2_ADDR` latch `evB1` and `evB2` bit for bit. Each clears when read, and that clears its summary bit.
- R7: A mask bit of 1 on a summary position hides the whole extended register from the primary read and from `irqOut`. The extended register keeps its contents and can still be read.
- R8: An event arriving in the same cycle as a clearing read of its register is kept.
- R9: The mask register at 06h is read/write. Writes to the primary or extended status addresses change nothing.
- R10: `irqOut` is high exactly while at least one unmasked primary bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Register address |
| wrData | input | 8 | Write data |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe; a read clears the addressed register on the clock edge |
| rdData | output | 8 | Read data of the addressed register, 0 when not reading |
| evPrim | input | 5 | Direct event pulses for primary bits 7..3 |
| evSig | input | 7 | Signalling-channel event pulses for extended bits 7..1 |
| evB1 | input | 8 | Bearer-1 event pulses |
| evB2 | input | 8 | Bearer-2 event pulses |
| irqOut | output | 1 | Interrupt request, active high |

## Verification
The bench drives the direct events through a table of event and mask combinations. The combinations are all-unmasked single and double events, a fully masked set, and partial masks that overlap the events. Together these show whether the mask gates each position on its own and whether a read clears only the returned bits. Directed sequences cover the rest. One holds a masked event across a read and then unmasks it, which separates "hidden" from "lost". Another reads the primary register repeatedly while an extended register is non-empty, which separates summary bits from direct bits. A third pulses an event in the cycle of a clearing read, which exposes clear-over-set priority.

// File: rtl/irq_tree_pkg.sv
package irq_tree_pkg;
  localparam int REG_W     = 8;
  localparam int PRIM_EV_W = 5;
  localparam int SIG_EV_W  = 7;
  localparam int NUM_BEAR  = 2;
  localparam int SUM_SIG_BIT = 2;
  localparam logic [7:0] MASK_ADDR = 8'h06;
  localparam logic [7:0] SIG_ADDR  = 8'h07;
  localparam logic [REG_W-1:0] MASK_RST = '1;

  typedef struct packed {
    logic                rdPrim;
    logic                rdMask;
    logic                rdSig;
    logic [NUM_BEAR-1:0] rdBear;
    logic                wrMask;
  } busStrobe_t;
endpackage

// File: rtl/irq_tree_latch.sv
module irq_tree_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] setV,
  input  logic [W-1:0] clrV,
  output logic [W-1:0] q
);
  // set has priority over clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) q <= '0;
    else       q <= (q & ~clrV) | setV;
  end
endmodule

// File: rtl/irq_tree_ctrl.sv
module irq_tree_ctrl
  import irq_tree_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] PRIM_ADDR = 8'h04,
  parameter logic [ADDR_W-1:0] B1_ADDR   = 8'h08,
  parameter logic [ADDR_W-1:0] B2_ADDR   = 8'h09
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdEn,
  input  logic              wrEn,
  output busStrobe_t        stb
);
  localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_ADDR);
  localparam logic [ADDR_W-1:0] SIG_A  = ADDR_W'(SIG_ADDR);

  always_comb begin
    stb.rdPrim    = rdEn && (addr == PRIM_ADDR);
    stb.rdMask    = rdEn && (addr == MASK_A);
    stb.rdSig     = rdEn && (addr == SIG_A);
    stb.rdBear[0] = rdEn && (addr == B1_ADDR);
    stb.rdBear[1] = rdEn && (addr == B2_ADDR);
    // only the mask register accepts writes
    stb.wrMask    = wrEn && (addr == MASK_A);
  end
endmodule

// File: rtl/irq_tree_dp.sv
module irq_tree_dp
  import irq_tree_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  busStrobe_t                     stb,
  input  logic [REG_W-1:0]               wrData,
  input  logic [PRIM_EV_W-1:0]           evPrim,
  input  logic [SIG_EV_W-1:0]            evSig,
  input  logic [NUM_BEAR-1:0][REG_W-1:0] evBear,
  output logic [REG_W-1:0]               rdData,
  output logic [REG_W-1:0]               maskQ,
  output logic [REG_W-1:0]               primRaw,
  output logic                           irqOut
);
  localparam int DIR_LO = REG_W - PRIM_EV_W;

  logic [PRIM_EV_W-1:0]           dirQ;
  logic [PRIM_EV_W-1:0]           dirClr;
  logic [SIG_EV_W-1:0]            sigQ;
  logic [NUM_BEAR-1:0][REG_W-1:0] bearQ;
  logic [NUM_BEAR-1:0]            sumBear;
  logic                           sumSig;
  logic [REG_W-1:0]               primVis;
  logic [REG_W-1:0]               sigVis;

  // mask register
  always_ff @(posedge clk) begin
    if (!rstN)           maskQ <= MASK_RST;
    else if (stb.wrMask) maskQ <= wrData;
  end

  // a primary read clears only the direct bits it actually showed
  assign dirClr = {PRIM_EV_W{stb.rdPrim}} & ~maskQ[REG_W-1:DIR_LO];

  irq_tree_latch #(.W(PRIM_EV_W)) u_dir (
    .clk(clk), .rstN(rstN), .setV(evPrim), .clrV(dirClr), .q(dirQ)
  );

  irq_tree_latch #(.W(SIG_EV_W)) u_sig (
    .clk(clk), .rstN(rstN), .setV(evSig),
    .clrV({SIG_EV_W{stb.rdSig}}), .q(sigQ)
  );

  for (genvar i = 0; i < NUM_BEAR; i++) begin : g_bear
    irq_tree_latch #(.W(REG_W)) u_bear (
      .clk(clk), .rstN(rstN), .setV(evBear[i]),
      .clrV({REG_W{stb.rdBear[i]}}), .q(bearQ[i])
    );
    // bearer 1 sits at bit 1, bearer 2 at bit 0
    assign sumBear[i] = |bearQ[i];
    assign primRaw[SUM_SIG_BIT-1-i] = sumBear[i];
  end

  assign sumSig  = |sigQ;
  assign primRaw[REG_W-1:DIR_LO] = dirQ;
  assign primRaw[SUM_SIG_BIT]    = sumSig;
  assign primVis = primRaw & ~maskQ;
  assign sigVis  = {sigQ, 1'b0};
  assign irqOut  = |primVis;

  always_comb begin
    rdData = '0;
    if (stb.rdPrim) rdData = rdData | primVis;
    if (stb.rdMask) rdData = rdData | maskQ;
    if (stb.rdSig)  rdData = rdData | sigVis;
    for (int i = 0; i < NUM_BEAR; i++)
      if (stb.rdBear[i]) rdData = rdData | bearQ[i];
  end
endmodule

// File: rtl/irq_tree.sv
module irq_tree
  import irq_tree_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] PRIM_ADDR = 8'h04,
  parameter logic [ADDR_W-1:0] B1_ADDR   = 8'h08,
  parameter logic [ADDR_W-1:0] B2_ADDR   = 8'h09
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic              wrEn,
  input  logic              rdEn,
  output logic [7:0]        rdData,
  input  logic [4:0]        evPrim,
  input  logic [6:0]        evSig,
  input  logic [7:0]        evB1,
  input  logic [7:0]        evB2,
  output logic              irqOut
);
  busStrobe_t                     stb;
  logic [NUM_BEAR-1:0][REG_W-1:0] evBear;
  logic [REG_W-1:0]               maskQ;
  logic [REG_W-1:0]               primRaw;

  assign evBear[0] = evB1;
  assign evBear[1] = evB2;

  irq_tree_ctrl #(
    .ADDR_W(ADDR_W), .PRIM_ADDR(PRIM_ADDR), .B1_ADDR(B1_ADDR), .B2_ADDR(B2_ADDR)
  ) u_ctrl (
    .addr(addr), .rdEn(rdEn), .wrEn(wrEn), .stb(stb)
  );

  irq_tree_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .evPrim(evPrim), .evSig(evSig), .evBear(evBear),
    .rdData(rdData), .maskQ(maskQ), .primRaw(primRaw), .irqOut(irqOut)
  );
endmodule

// File: rtl/irq_tree_chk.sv
module irq_tree_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] PRIM_ADDR = 8'h04,
  parameter logic [ADDR_W-1:0] B1_ADDR   = 8'h08
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic              rdEn,
  input logic [7:0]        rdData,
  input logic [4:0]        evPrim,
  input logic [7:0]        evB1,
  input logic [7:0]        maskQ,
  input logic [7:0]        primRaw
);
  localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(8'h06);
  localparam logic [ADDR_W-1:0] SIG_A  = ADDR_W'(8'h07);

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    evPrim[4] |=> primRaw[7]);

  a_r3_summary_survives: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == PRIM_ADDR) |=>
      ((primRaw[2:0] & $past(primRaw[2:0])) == $past(primRaw[2:0])));

  a_r4_masked_kept: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == PRIM_ADDR && maskQ[7] && primRaw[7]) |=> primRaw[7]);

  a_r9_mask_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr == MASK_A) |=> $stable(maskQ));

  a_r5_bit0_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == SIG_A) |-> !rdData[0]);

  a_r6_b1_clear: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == B1_ADDR && evB1 == 8'h00) |=> !primRaw[1]);
endmodule

bind irq_tree irq_tree_chk #(
  .ADDR_W(ADDR_W), .PRIM_ADDR(PRIM_ADDR), .B1_ADDR(B1_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
  .rdData(rdData), .evPrim(evPrim), .evB1(evB1),
  .maskQ(maskQ), .primRaw(primRaw)
);

// File: tb/irq_tree_tb.sv
`timescale 1ns/1ps
module irq_tree_tb;
  localparam logic [7:0] PRIM = 8'h04;
  localparam logic [7:0] MSK  = 8'h06;
  localparam logic [7:0] SIG  = 8'h07;
  localparam logic [7:0] B1   = 8'h08;
  localparam logic [7:0] B2   = 8'h09;
  localparam int NVEC = 6;
  // {evPrim, mask, expected primary read}
  localparam logic [20:0] VEC [NVEC] = '{
    {5'b10000, 8'h00, 8'h80},
    {5'b01001, 8'h00, 8'h48},
    {5'b11111, 8'hF8, 8'h00},
    {5'b11111, 8'h50, 8'hA8},
    {5'b00110, 8'h08, 8'h30},
    {5'b00001, 8'h07, 8'h08}
  };

  logic clk = 0, rstN = 0, wrEn = 0, rdEn = 0, irqOut;
  logic [7:0] addr = 0, wrData = 0, rdData, evB1 = 0, evB2 = 0;
  logic [4:0] evPrim = 0;
  logic [6:0] evSig = 0;
  int total = 0, bad = 0;
  logic [7:0] v;

  always #2.5 clk = ~clk;

  irq_tree u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn),
    .rdEn(rdEn), .rdData(rdData), .evPrim(evPrim), .evSig(evSig),
    .evB1(evB1), .evB2(evB2), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rdEn = 1;
    #1 d = rdData;
    @(negedge clk); rdEn = 0;
  endtask

  task automatic pulse(input logic [4:0] p, input logic [6:0] s,
                       input logic [7:0] b1, input logic [7:0] b2);
    @(negedge clk); evPrim = p; evSig = s; evB1 = b1; evB2 = b2;
    @(negedge clk); evPrim = 0; evSig = 0; evB1 = 0; evB2 = 0;
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    #1 chk("R1 irq", {7'b0, irqOut}, 8'h00);
    rd(MSK, v);  chk("R1 mask", v, 8'hFF);
    rd(PRIM, v); chk("R1 prim", v, 8'h00);
    rd(SIG, v);  chk("R1 sig", v, 8'h00);
    rd(B1, v);   chk("R1 b1", v, 8'h00);

    // R2 / R10 table of event and mask patterns
    for (int i = 0; i < NVEC; i++) begin
      wr(MSK, VEC[i][15:8]);
      pulse(VEC[i][20:16], 7'h0, 8'h0, 8'h0);
      #1 chk("R10 irq vec", {7'b0, irqOut}, {7'b0, |VEC[i][7:0]});
      rd(PRIM, v); chk("R2 prim vec", v, VEC[i][7:0]);
      wr(MSK, 8'h00);
      rd(PRIM, v);
    end

    // R4 masked event held across read, visible after unmask
    wr(MSK, 8'h80);
    pulse(5'b10000, 7'h0, 8'h0, 8'h0);
    #1 chk("R4 irq masked", {7'b0, irqOut}, 8'h00);
    rd(PRIM, v); chk("R4 hidden", v, 8'h00);
    wr(MSK, 8'h00);
    #1 chk("R10 irq unmasked", {7'b0, irqOut}, 8'h01);
    rd(PRIM, v); chk("R4 revealed", v, 8'h80);
    rd(PRIM, v); chk("R3 cleared", v, 8'h00);

    // R5 / R3 signalling register and its summary
    pulse(5'b0, 7'b1000001, 8'h0, 8'h0);
    rd(PRIM, v); chk("R5 summary", v, 8'h04);
    rd(PRIM, v); chk("R3 summary kept", v, 8'h04);
    rd(SIG, v);  chk("R5 sig read", v, 8'h82);
    rd(PRIM, v); chk("R5 summary cleared", v, 8'h00);
    rd(SIG, v);  chk("R5 sig cleared", v, 8'h00);

    // R6 bearer registers
    pulse(5'b0, 7'h0, 8'h3C, 8'h00);
    rd(PRIM, v); chk("R6 b1 summary", v, 8'h02);
    rd(B1, v);   chk("R6 b1 read", v, 8'h3C);
    rd(PRIM, v); chk("R6 b1 cleared", v, 8'h00);
    pulse(5'b0, 7'h0, 8'h00, 8'h01);
    rd(PRIM, v); chk("R6 b2 summary", v, 8'h01);
    rd(B2, v);   chk("R6 b2 read", v, 8'h01);
    rd(PRIM, v); chk("R6 b2 cleared", v, 8'h00);

    // R7 summary mask hides extended register
    wr(MSK, 8'h04);
    pulse(5'b0, 7'b0010000, 8'h0, 8'h0);
    #1 chk("R7 irq", {7'b0, irqOut}, 8'h00);
    rd(PRIM, v); chk("R7 prim", v, 8'h00);
    rd(SIG, v);  chk("R7 sig kept", v, 8'h20);
    wr(MSK, 8'h00);
    rd(PRIM, v); chk("R7 after clear", v, 8'h00);

    // R8 event coinciding with clearing read
    pulse(5'b00100, 7'h0, 8'h0, 8'h0);
    @(negedge clk); addr = PRIM; rdEn = 1; evPrim = 5'b01000;
    #1 v = rdData;
    @(negedge clk); rdEn = 0; evPrim = 0;
    chk("R8 read", v, 8'h20);
    rd(PRIM, v); chk("R8 prim kept", v, 8'h40);
    pulse(5'b0, 7'b0000001, 8'h0, 8'h0);
    @(negedge clk); addr = SIG; rdEn = 1; evSig = 7'b0000010;
    #1 v = rdData;
    @(negedge clk); rdEn = 0; evSig = 0;
    chk("R8 sig read", v, 8'h02);
    rd(SIG, v); chk("R8 sig kept", v, 8'h04);

    // R9 writes to status addresses ignored, mask readback
    wr(MSK, 8'h5A);
    rd(MSK, v);  chk("R9 mask readback", v, 8'h5A);
    wr(PRIM, 8'hFF); wr(SIG, 8'hFF); wr(B1, 8'hFF); wr(B2, 8'hFF);
    rd(MSK, v);  chk("R9 mask unchanged", v, 8'h5A);
    wr(MSK, 8'h00);
    rd(PRIM, v); chk("R9 prim", v, 8'h00);
    rd(SIG, v);  chk("R9 sig", v, 8'h00);
    rd(B1, v);   chk("R9 b1", v, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule